// File: doc/BRIEF.md
# Paired-Board Self-Trigger Coincidence Unit

This block decides when a front-end board reads out its stored charge in a self-triggered two-board setup. A discriminator hit counts only if it lands inside a live integration window. Such a hit becomes a local trigger, which is sent to the partner board over a short ribbon link. The same local trigger also passes through a programmable delay, so that it reaches the accept logic in the same cycle as the partner's copy of a trigger from the same crossing. A source mode selects which triggers may cause an accept. Each accept is followed by a hold-off of one crossing period, so one particle cannot be read out twice.

One board acts as master and the other as slave. The master runs a frame counter and drives the first-crossing sync pulse onto the link a programmable number of cycles early. The slave delays the received pulse by the same amount, so both boards mark the frame start in the same cycle.

Top module: `selftrig_coinc`

## Requirements
- R1: `local_trig_o` is high for exactly one cycle, starting at the clock edge that samples `hit_i` and `live_i` both high. It stays low if either of them is low.
- R2: With the internal source enabled and `trig_delay_i` = D (0 to 7), a local trigger that begins at edge k produces `l1a_o` high after edge k+D+1.
- R3: With the external source enabled, `partner_trig_i` sampled high at an edge produces `l1a_o` high right after that same edge.
- R4: `src_mode_i` encodes the trigger source as follows: 2'b00 uses internal triggers only, 2'b01 uses external triggers only, and 2'b10 or 2'b11 uses both. A trigger from a disabled source never causes `l1a_o`.
- R5: When an aligned internal trigger and an external trigger arrive in the same cycle, they produce a single accept.
- R6: `l1a_o` is never high for two consecutive cycles.
- R7: After an accept, no further accept occurs during the next CROSS_PERIOD-1 cycles (default 8). A trigger arriving exactly CROSS_PERIOD cycles after the previous accept is accepted.
- R8: In master mode, `frame_sync_o` is a one-cycle pulse every FRAME_LEN cycles (default 64). The first pulse is in the cycle after the first clock edge following reset release.
- R9: In master mode, `link_sync_o` pulses `sync_adv_i`+1 cycles before each `frame_sync_o` pulse, so the two never coincide. In slave mode, `link_sync_o` stays low.
- R10: In slave mode, `link_sync_i` sampled high at edge k makes `frame_sync_o` high for one cycle after edge k+A, where A = `sync_adv_i`.
- R11: While `rst_ni` is low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master board, 0 = slave board |
| src_mode_i | input | 2 | Trigger source select (see R4) |
| trig_delay_i | input | DLY_W | Delay, in ticks, applied to the internal trigger |
| sync_adv_i | input | DLY_W | Advance of the link sync, in ticks |
| hit_i | input | 1 | Discriminator above threshold |
| live_i | input | 1 | Live integration window flag |
| partner_trig_i | input | 1 | Trigger received from the partner board |
| link_sync_i | input | 1 | Early sync received from the master (slave mode) |
| local_trig_o | output | 1 | Local trigger sent to the partner |
| l1a_o | output | 1 | Aligned one-cycle accept pulse for readout |
| link_sync_o | output | 1 | Early sync sent to the slave (master mode) |
| frame_sync_o | output | 1 | First-crossing frame pulse used by this board |

## Verification
The checker watches every cycle for these properties:
- the local trigger is always the previous cycle's hit-and-live coincidence;
- accepts are single-cycle and spaced at least one crossing period apart;
- in external-only mode, every accept is preceded by a partner trigger;
- the master's frame pulse is single-cycle and never overlaps the link pulse.

The exact internal-delay count, the merging of coincident triggers, and the acceptance of a trigger exactly one period after the last accept can only be shown by the bench's scenarios. The same holds for the absence of accepts from a disabled source, the master's frame period and sync lead, and the slave's reconstructed frame timing.

// File: rtl/stc_pkg.sv
package stc_pkg;

   typedef enum logic [1:0] {
      SRC_INT      = 2'b00,
      SRC_EXT      = 2'b01,
      SRC_BOTH     = 2'b10,
      SRC_BOTH_ALT = 2'b11
   } src_mode_e;

   function automatic logic use_internal(input logic [1:0] mode);
      return mode != SRC_EXT;
   endfunction

   function automatic logic use_external(input logic [1:0] mode);
      return mode != SRC_INT;
   endfunction

endpackage

// File: rtl/stc_tap_line.sv
// Shift line with a selectable output tap.
// BYPASS=1: tap 0 is the input itself, tap n is n registers deep.
// BYPASS=0: tap n is n+1 registers deep.
module stc_tap_line #(
   parameter int SEL_W  = 3,
   parameter bit BYPASS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             d_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             q_o
);
   localparam int TAPS   = 2 ** SEL_W;
   localparam int STAGES = BYPASS ? TAPS - 1 : TAPS;

   if (SEL_W < 2) begin : g_bad_sel
      $error("stc_tap_line: SEL_W must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   if (BYPASS) begin : g_bypass
      always_comb begin
         if (sel_i == '0) q_o = d_i;
         else             q_o = stage_q[sel_i - 1'b1];
      end
   end else begin : g_registered
      assign q_o = stage_q[sel_i];
   end

endmodule

// File: rtl/stc_sync_gen.sv
// Frame sync generation: master counter with early link pulse,
// or slave reconstruction of the frame from the received link pulse.
module stc_sync_gen #(
   parameter int FRAME_LEN = 64,
   parameter int DLY_W     = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             master_i,
   input  logic [DLY_W-1:0] adv_i,
   input  logic             link_sync_i,
   output logic             link_sync_o,
   output logic             frame_sync_o
);
   localparam int CNT_W = $clog2(FRAME_LEN);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_LEN - 1);

   if (FRAME_LEN <= (2 ** DLY_W) + 1) begin : g_bad_frame
      $error("stc_sync_gen: FRAME_LEN must exceed the largest advance plus one");
   end
   if (CNT_W <= DLY_W) begin : g_bad_width
      $error("stc_sync_gen: counter narrower than advance field");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [CNT_W-1:0] link_pos;
   logic             m_frame;
   logic             m_link;
   logic             s_frame;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         run_q <= 1'b1;
         if (run_q) begin
            if (cnt_q == LAST_C) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // The link pulse leads the frame pulse by adv+1 cycles; the extra cycle
   // is the slave's capture register.
   assign link_pos = LAST_C - {{(CNT_W-DLY_W){1'b0}}, adv_i};
   assign m_frame  = run_q && (cnt_q == '0);
   assign m_link   = run_q && (cnt_q == link_pos);

   stc_tap_line #(
      .SEL_W  (DLY_W),
      .BYPASS (1'b0)
   ) slave_line_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (link_sync_i),
      .sel_i  (adv_i),
      .q_o    (s_frame)
   );

   assign frame_sync_o = master_i ? m_frame : s_frame;
   assign link_sync_o  = master_i & m_link;

endmodule

// File: rtl/stc_accept.sv
// Merges aligned triggers per source mode and enforces the hold-off.
module stc_accept
   import stc_pkg::*;
#(
   parameter int CROSS_PERIOD = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] mode_i,
   input  logic       int_trig_i,
   input  logic       ext_trig_i,
   output logic       l1a_o
);
   localparam int HOLD_W = (CROSS_PERIOD > 2) ? $clog2(CROSS_PERIOD) : 1;
   localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(CROSS_PERIOD - 1);

   if (CROSS_PERIOD < 2) begin : g_bad_period
      $error("stc_accept: CROSS_PERIOD must be at least 2");
   end

   logic              cand;
   logic              fire;
   logic [HOLD_W-1:0] hold_q;

   assign cand = (use_internal(mode_i) & int_trig_i) |
                 (use_external(mode_i) & ext_trig_i);
   assign fire = cand && (hold_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= '0;
         l1a_o  <= 1'b0;
      end else begin
         l1a_o <= fire;
         if (fire)               hold_q <= HOLD_LOAD;
         else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
      end
   end

endmodule

// File: rtl/selftrig_coinc.sv
module selftrig_coinc #(
   parameter int DLY_W        = 3,
   parameter int FRAME_LEN    = 64,
   parameter int CROSS_PERIOD = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             master_i,
   input  logic [1:0]       src_mode_i,
   input  logic [DLY_W-1:0] trig_delay_i,
   input  logic [DLY_W-1:0] sync_adv_i,
   input  logic             hit_i,
   input  logic             live_i,
   input  logic             partner_trig_i,
   input  logic             link_sync_i,
   output logic             local_trig_o,
   output logic             l1a_o,
   output logic             link_sync_o,
   output logic             frame_sync_o
);
   if (DLY_W < 2 || DLY_W > 4) begin : g_bad_dly
      $error("selftrig_coinc: DLY_W must be 2..4");
   end

   logic local_q;
   logic int_aligned;

   // Hit qualified by the live window, registered once.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) local_q <= 1'b0;
      else         local_q <= hit_i & live_i;
   end
   assign local_trig_o = local_q;

   // Internal trigger delayed to meet the partner's copy.
   stc_tap_line #(
      .SEL_W  (DLY_W),
      .BYPASS (1'b1)
   ) trig_line_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (local_q),
      .sel_i  (trig_delay_i),
      .q_o    (int_aligned)
   );

   stc_accept #(
      .CROSS_PERIOD (CROSS_PERIOD)
   ) accept_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (src_mode_i),
      .int_trig_i (int_aligned),
      .ext_trig_i (partner_trig_i),
      .l1a_o      (l1a_o)
   );

   stc_sync_gen #(
      .FRAME_LEN (FRAME_LEN),
      .DLY_W     (DLY_W)
   ) sync_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .master_i     (master_i),
      .adv_i        (sync_adv_i),
      .link_sync_i  (link_sync_i),
      .link_sync_o  (link_sync_o),
      .frame_sync_o (frame_sync_o)
   );

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
   parameter int CROSS_PERIOD = 8
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       master_i,
   input logic [1:0] src_mode_i,
   input logic       hit_i,
   input logic       live_i,
   input logic       partner_trig_i,
   input logic       local_trig_o,
   input logic       l1a_o,
   input logic       link_sync_o,
   input logic       frame_sync_o
);
   localparam int GAP_W = $clog2(CROSS_PERIOD + 1);
   localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(CROSS_PERIOD);

   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              gap_q <= GAP_MAX;
      else if (l1a_o)           gap_q <= GAP_W'(1);
      else if (gap_q < GAP_MAX) gap_q <= gap_q + 1'b1;
   end

   p_local_needs_live_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      local_trig_o |-> $past(hit_i && live_i));

   p_accept_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1a_o |=> !l1a_o);

   p_holdoff_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1a_o |-> (gap_q >= GAP_MAX));

   p_ext_only_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1a_o && src_mode_i == 2'b01 && $past(src_mode_i) == 2'b01) |-> $past(partner_trig_i));

   p_frame_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_i && frame_sync_o) |=> !frame_sync_o);

   p_link_frame_apart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_sync_o |-> !frame_sync_o);

endmodule

bind selftrig_coinc stc_checker #(.CROSS_PERIOD(CROSS_PERIOD)) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .master_i       (master_i),
   .src_mode_i     (src_mode_i),
   .hit_i          (hit_i),
   .live_i         (live_i),
   .partner_trig_i (partner_trig_i),
   .local_trig_o   (local_trig_o),
   .l1a_o          (l1a_o),
   .link_sync_o    (link_sync_o),
   .frame_sync_o   (frame_sync_o)
);

// File: tb/selftrig_coinc_tb_top.sv
`timescale 1ns/1ps
module selftrig_coinc_tb_top;

   localparam int FRAME_LEN = 64;
   localparam int NV = 10;
   // mode, delay, hit_at, live, ext_at, expected first accept, expected accepts
   localparam int VEC [NV][7] = '{
      '{0, 0,  2, 1, -1,  3, 1},
      '{0, 3,  2, 1, -1,  6, 1},
      '{0, 7,  1, 1, -1,  9, 1},
      '{0, 2,  2, 0, -1, -1, 0},
      '{1, 0, -1, 0,  4,  4, 1},
      '{0, 0, -1, 0,  4, -1, 0},
      '{1, 0,  2, 1, -1, -1, 0},
      '{2, 2,  2, 1,  5,  5, 1},
      '{2, 0,  2, 1,  9,  3, 1},
      '{3, 0,  2, 1, 11,  3, 2}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master = 1'b1;
   logic [1:0] mode = 2'b00;
   logic [2:0] dly = '0;
   logic [2:0] adv = 3'd3;
   logic       hit = 1'b0;
   logic       live = 1'b0;
   logic       partner = 1'b0;
   logic       link_in = 1'b0;
   logic       local_trig, l1a, link_out, frame;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   selftrig_coinc dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .master_i       (master),
      .src_mode_i     (mode),
      .trig_delay_i   (dly),
      .sync_adv_i     (adv),
      .hit_i          (hit),
      .live_i         (live),
      .partner_trig_i (partner),
      .link_sync_i    (link_in),
      .local_trig_o   (local_trig),
      .l1a_o          (l1a),
      .link_sync_o    (link_out),
      .frame_sync_o   (frame)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      hit = 1'b0; live = 1'b0; partner = 1'b0; link_in = 1'b0;
      for (int i = 0; i < n; i++) step();
   endtask

   function automatic string vtag(input int v);
      case (v)
         0: return "R2 internal delay 0";
         1: return "R2 internal delay 3";
         2: return "R2 internal delay 7";
         3: return "R1 hit outside live window";
         4: return "R3 external path";
         5: return "R4 external ignored in internal mode";
         6: return "R4 internal ignored in external mode";
         7: return "R5 coincident triggers merged";
         8: return "R7 hold-off blocks early trigger";
         default: return "R7 trigger one period later accepted";
      endcase
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int fcnt, ffirst, flast, lcnt, lfirst, acnt, afirst, tcnt;

      // R11: outputs low in reset, inputs active
      hit = 1'b1; live = 1'b1; partner = 1'b1; link_in = 1'b1;
      for (int i = 0; i < 3; i++) step();
      check(local_trig == 1'b0, "R11 local_trig in reset", local_trig, 0);
      check(l1a == 1'b0, "R11 l1a in reset", l1a, 0);
      check(link_out == 1'b0, "R11 link_sync in reset", link_out, 0);
      check(frame == 1'b0, "R11 frame_sync in reset", frame, 0);
      hit = 1'b0; live = 1'b0; partner = 1'b0; link_in = 1'b0;
      rst_n = 1'b1;

      // R8/R9: master frame period and link lead (adv = 3)
      fcnt = 0; ffirst = -1; flast = -1; lcnt = 0; lfirst = -1;
      for (int c = 0; c < 2 * FRAME_LEN + 2; c++) begin
         step();
         if (frame) begin
            fcnt++;
            if (ffirst < 0) ffirst = c;
            flast = c;
         end
         if (link_out) begin
            lcnt++;
            if (lfirst < 0) lfirst = c;
         end
      end
      check(ffirst == 0, "R8 first frame pulse", ffirst, 0);
      check(fcnt == 3 && flast == 2 * FRAME_LEN, "R8 frame period", flast, 2 * FRAME_LEN);
      check(lcnt == 2, "R9 link pulse count", lcnt, 2);
      check(lfirst == FRAME_LEN - 4, "R9 link lead adv+1", lfirst, FRAME_LEN - 4);

      // Trigger scenarios from the table
      for (int v = 0; v < NV; v++) begin
         mode = 2'(VEC[v][0]);
         dly  = 3'(VEC[v][1]);
         idle(10);
         lcnt = 0; acnt = 0; afirst = -1;
         for (int c = 0; c < 16; c++) begin
            hit     = (c == VEC[v][2]);
            live    = (c == VEC[v][2]) && (VEC[v][3] == 1);
            partner = (c == VEC[v][4]);
            step();
            if (local_trig) lcnt++;
            if (l1a) begin
               acnt++;
               if (afirst < 0) afirst = c;
            end
         end
         check(lcnt == ((VEC[v][2] >= 0 && VEC[v][3] == 1) ? 1 : 0),
               {vtag(v), " / R1 local trigger"}, lcnt,
               (VEC[v][2] >= 0 && VEC[v][3] == 1) ? 1 : 0);
         check(acnt == VEC[v][6], {vtag(v), " / R6 accept count"}, acnt, VEC[v][6]);
         check(afirst == VEC[v][5], {vtag(v), " accept cycle"}, afirst, VEC[v][5]);
      end

      // R10/R9: slave rebuilds frame from link pulse
      master = 1'b0;
      for (int k = 0; k < 2; k++) begin
         adv = (k == 0) ? 3'd0 : 3'd5;
         idle(10);
         fcnt = 0; ffirst = -1; tcnt = 0;
         for (int c = 0; c < 12; c++) begin
            link_in = (c == 2);
            step();
            if (frame) begin
               fcnt++;
               if (ffirst < 0) ffirst = c;
            end
            if (link_out) tcnt++;
         end
         check(ffirst == 2 + int'(adv), "R10 slave frame position", ffirst, 2 + int'(adv));
         check(fcnt == 1, "R10 slave frame single", fcnt, 1);
         check(tcnt == 0, "R9 slave link output low", tcnt, 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule